// File: doc/BRIEF.md
# Peripheral-FIFO Burst DMA Channel

This block is one DMA channel that carries data between a fixed peripheral FIFO and system memory in bursts of 32 bytes. Software sets it up through a small register file: the source and destination addresses, a count of 32-byte units, a byte-valid mask for the final burst, and a control word. Once enabled, the channel raises a burst request on a simple request/acknowledge memory port. It presents the memory-side address there: the destination when it moves device data into memory, the source when it moves memory data out to the device. After each acknowledged burst it adds 32 to that address and subtracts one from the count. Software can therefore work out the bytes still to move from the distance the address has travelled.

When the count reaches zero the channel flags the end of the transfer and can interrupt. If the peripheral FIFO receives a zero-length packet while the channel is running, a null-packet flag is set. Software answers it by clearing the flag and setting the forced-end bit in the same write, which ends the transfer at once. A global register enables all movement and reports address errors. A soft-reset register holds the whole controller cleared for as long as its bit is set. Scatter-gather sequencing stays in software.

Top module: `pfifo_burst_dma`

Register map (byte offsets on the register port, channel base = 0x20 + 0x20 × `CH_INDEX`): soft reset at 0x08 (bit 0 = hold reset), global at 0x60 (bit 0 = global enable, bit 1 = address error). Channel: +0x00 source, +0x04 destination, +0x08 count (24 bits), +0x14 control, +0x18 final mask. Control bits: 0 = enable, 1 = transfer end, 2 = stopped on error, 3 = direction (1 = device to memory), 5 = interrupt enable, 7:6 = transfer size code (stored only), 12 = null packet, 16 = null interrupt enable, 24 = forced end.

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Writing the global register with bit 0 = 1 and bit 1 = 0 reads back 1. While global enable is 0, an enabled channel issues no request and its count and addresses hold. Setting global enable again resumes the transfer.
- R3: Each burst request presents the memory-side address: the destination when control bit 3 is 1, with `mem_we` = 1; the source when bit 3 is 0, with `mem_we` = 0. Each acknowledged burst adds 32 to that address and subtracts 1 from the count. The other address register is left unchanged.
- R4: `mem_be` is all ones on every burst except the one issued with count = 1. On that burst it equals the final-mask register, whose bit 31 marks the first byte and whose valid bytes are leading ones from bit 31.
- R5: When the count reaches zero on an enabled channel, control bit 1 (transfer end) sets. No further request is issued. The memory-side address ends at start + 32 × (units programmed).
- R6: Control bits 1, 2 and 12 are cleared by writing 0 to them and are unchanged by writing 1. All other control fields, the addresses, the count and the mask read back as written.
- R7: A null-packet pulse on `fifo_null` sets control bit 12 only while the channel is busy (enable = 1, transfer end = 0) and global enable = 1. At any other time it is ignored.
- R8: Setting control bit 24 on a busy channel sets transfer end within two cycles, stops requests and holds the count.
- R9: `irq` = interrupt-enable AND (transfer end OR stopped OR (null packet AND null enable)).
- R10: A burst whose memory-side address is not 32-byte aligned is not requested. Instead, global bit 1 and control bit 2 set. Writing 1 to global bit 1 leaves it set; writing 0 clears it.
- R11: While the soft-reset bit is 1, every other register reads 0 and writes to them are ignored. Clearing the bit leaves the reset values.
- R12: Enabling a channel whose count is 0 sets transfer end without issuing any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | 1 = burst writes memory (device to memory) |
| mem_addr | output | 32 | Burst start address |
| mem_be | output | 32 | Byte valid mask of the burst, bit 31 = first byte |
| mem_ack | input | 1 | Burst accepted in this cycle |
| fifo_null | input | 1 | Peripheral FIFO received a zero-length packet |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the block with its defaults: channel index 0, 32-bit addresses, a 24-bit count and 32-byte bursts. It sweeps every transfer length from 1 to 96 bytes in both directions. That covers all 32 remainders of the final-burst mask, including the full-mask case, and one-, two- and three-burst transfers, with the acknowledge delay varied between them. Directed sequences then cover the event paths: the global-enable pause, forced end, null-packet conversion, a misaligned address error, a zero count and the held soft reset.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam logic [7:0] OFS_SWR  = 8'h08;
    localparam logic [7:0] OFS_GLB  = 8'h60;
    localparam logic [7:0] CH_FIRST = 8'h20;
    localparam logic [7:0] CH_STEP  = 8'h20;
    localparam logic [7:0] OFS_SRC  = 8'h00;
    localparam logic [7:0] OFS_DST  = 8'h04;
    localparam logic [7:0] OFS_CNT  = 8'h08;
    localparam logic [7:0] OFS_CTL  = 8'h14;
    localparam logic [7:0] OFS_MSK  = 8'h18;

    typedef struct packed {
        logic       en;
        logic       tend;
        logic       stop;
        logic       dir;
        logic       ien;
        logic [1:0] tsz;
        logic       nul;
        logic       nulen;
        logic       force_end;
    } ctl_t;

    function automatic logic [31:0] ctl_pack(input ctl_t c);
        logic [31:0] v;
        v     = '0;
        v[0]  = c.en;
        v[1]  = c.tend;
        v[2]  = c.stop;
        v[3]  = c.dir;
        v[5]  = c.ien;
        v[7:6] = c.tsz;
        v[12] = c.nul;
        v[16] = c.nulen;
        v[24] = c.force_end;
        return v;
    endfunction
endpackage

// File: rtl/pfd_ctrl_regs.sv
module pfd_ctrl_regs
    import pfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_glb,
    input  logic        wr_swr,
    input  logic        wr_ctl,
    input  logic [31:0] wdata,
    input  logic        done_set,
    input  logic        err_set,
    input  logic        null_evt,
    output ctl_t        ctl,
    output logic        gen,
    output logic        aerr,
    output logic        swr,
    output logic        run,
    output logic        busy,
    output logic        irq
);
    typedef struct packed {
        logic gen;
        logic aerr;
        logic swr;
        ctl_t ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.swr) begin
            st_d      = '0;
            st_d.swr  = 1'b1;
            if (wr_swr) st_d.swr = wdata[0];
        end else begin
            if (wr_swr) st_d.swr = wdata[0];
            if (wr_glb) begin
                st_d.gen  = wdata[0];
                st_d.aerr = st_q.aerr & wdata[1];
            end
            if (wr_ctl) begin
                st_d.ctl.en        = wdata[0];
                st_d.ctl.tend      = st_q.ctl.tend & wdata[1];
                st_d.ctl.stop      = st_q.ctl.stop & wdata[2];
                st_d.ctl.dir       = wdata[3];
                st_d.ctl.ien       = wdata[5];
                st_d.ctl.tsz       = wdata[7:6];
                st_d.ctl.nul       = st_q.ctl.nul & wdata[12];
                st_d.ctl.nulen     = wdata[16];
                st_d.ctl.force_end = wdata[24];
            end
            if (done_set) st_d.ctl.tend = 1'b1;
            if (err_set) begin
                st_d.aerr     = 1'b1;
                st_d.ctl.stop = 1'b1;
            end
            if (null_evt && busy && st_q.gen) st_d.ctl.nul = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl  = st_q.ctl;
    assign gen  = st_q.gen;
    assign aerr = st_q.aerr;
    assign swr  = st_q.swr;
    assign busy = st_q.ctl.en & ~st_q.ctl.tend;
    assign run  = busy & st_q.gen & ~st_q.aerr & ~st_q.ctl.stop & ~st_q.swr;
    assign irq  = st_q.ctl.ien &
                  (st_q.ctl.tend | st_q.ctl.stop | (st_q.ctl.nul & st_q.ctl.nulen));

    // R11
    swr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.swr |=> (!st_q.gen && !st_q.aerr && st_q.ctl == '0));

    // R5
    tend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctl.tend) |-> $past(done_set));

    // R10
    aerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.aerr) |-> $past(err_set));
endmodule

// File: rtl/pfd_xfer_engine.sv
module pfd_xfer_engine #(
    parameter int AW = 32,
    parameter int CW = 24,
    parameter int BB = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swr,
    input  logic          run,
    input  logic          force_end,
    input  logic          dir,
    input  logic          wr_src,
    input  logic          wr_dst,
    input  logic          wr_cnt,
    input  logic          wr_msk,
    input  logic [31:0]   wdata,
    input  logic          mem_ack,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic [BB-1:0] msk,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BB-1:0] mem_be,
    output logic          done_set,
    output logic          err_set
);
    localparam int OW = $clog2(BB);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [BB-1:0] msk;
    } eng_t;

    eng_t e_d, e_q;
    logic [AW-1:0] cur;
    logic          aligned;
    logic          has_units;
    logic          wr_any;

    assign cur       = dir ? e_q.dst : e_q.src;
    assign aligned   = (cur[OW-1:0] == '0);
    assign has_units = (e_q.cnt != '0);
    assign wr_any    = wr_src | wr_dst | wr_cnt | wr_msk;

    always_comb begin
        e_d = e_q;
        if (swr) begin
            e_d = '0;
        end else begin
            if (mem_req && mem_ack) begin
                if (dir) e_d.dst = e_q.dst + AW'(BB);
                else     e_d.src = e_q.src + AW'(BB);
                e_d.cnt = e_q.cnt - CW'(1);
            end
            if (wr_src) e_d.src = wdata[AW-1:0];
            if (wr_dst) e_d.dst = wdata[AW-1:0];
            if (wr_cnt) e_d.cnt = wdata[CW-1:0];
            if (wr_msk) e_d.msk = wdata[BB-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign mem_req  = run & has_units & aligned & ~force_end;
    assign mem_we   = dir;
    assign mem_addr = cur;
    assign mem_be   = (e_q.cnt == CW'(1)) ? e_q.msk : '1;
    assign done_set = run & (~has_units | force_end);
    assign err_set  = run & has_units & ~aligned & ~force_end;

    assign src = e_q.src;
    assign dst = e_q.dst;
    assign cnt = e_q.cnt;
    assign msk = e_q.msk;

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !wr_any && !swr) |=> (e_q.cnt == $past(e_q.cnt) - CW'(1)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !wr_any && !swr) |=> $stable(mem_addr));

    // R12
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.cnt == '0 && !wr_cnt) |=> (e_q.cnt == '0));
endmodule

// File: rtl/pfifo_burst_dma.sv
module pfifo_burst_dma
    import pfd_pkg::*;
#(
    parameter int CH_INDEX = 0,
    parameter int AW       = 32,
    parameter int CW       = 24,
    parameter int BB       = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [BB-1:0] mem_be,
    input  logic          mem_ack,
    input  logic          fifo_null,
    output logic          irq
);
    localparam logic [7:0] CH_BASE = CH_FIRST + 8'(CH_INDEX) * CH_STEP;

    ctl_t          ctl;
    logic          gen, aerr, swr, run, busy;
    logic          done_set, err_set;
    logic [AW-1:0] src, dst;
    logic [CW-1:0] cnt;
    logic [BB-1:0] msk;
    logic          sel_src, sel_dst, sel_cnt, sel_ctl, sel_msk, sel_glb, sel_swr;

    assign sel_src = (reg_addr == CH_BASE + OFS_SRC);
    assign sel_dst = (reg_addr == CH_BASE + OFS_DST);
    assign sel_cnt = (reg_addr == CH_BASE + OFS_CNT);
    assign sel_ctl = (reg_addr == CH_BASE + OFS_CTL);
    assign sel_msk = (reg_addr == CH_BASE + OFS_MSK);
    assign sel_glb = (reg_addr == OFS_GLB);
    assign sel_swr = (reg_addr == OFS_SWR);

    pfd_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_glb   (reg_we & sel_glb),
        .wr_swr   (reg_we & sel_swr),
        .wr_ctl   (reg_we & sel_ctl),
        .wdata    (reg_wdata),
        .done_set (done_set),
        .err_set  (err_set),
        .null_evt (fifo_null),
        .ctl      (ctl),
        .gen      (gen),
        .aerr     (aerr),
        .swr      (swr),
        .run      (run),
        .busy     (busy),
        .irq      (irq)
    );

    pfd_xfer_engine #(.AW(AW), .CW(CW), .BB(BB)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .swr       (swr),
        .run       (run),
        .force_end (ctl.force_end),
        .dir       (ctl.dir),
        .wr_src    (reg_we & sel_src & ~swr),
        .wr_dst    (reg_we & sel_dst & ~swr),
        .wr_cnt    (reg_we & sel_cnt & ~swr),
        .wr_msk    (reg_we & sel_msk & ~swr),
        .wdata     (reg_wdata),
        .mem_ack   (mem_ack),
        .src       (src),
        .dst       (dst),
        .cnt       (cnt),
        .msk       (msk),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .done_set  (done_set),
        .err_set   (err_set)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_src)      reg_rdata = 32'(src);
        else if (sel_dst) reg_rdata = 32'(dst);
        else if (sel_cnt) reg_rdata = 32'(cnt);
        else if (sel_ctl) reg_rdata = ctl_pack(ctl);
        else if (sel_msk) reg_rdata = 32'(msk);
        else if (sel_glb) reg_rdata = {30'd0, aerr, gen};
        else if (sel_swr) reg_rdata = {31'd0, swr};
    end

    // R2
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (gen && busy));

    // R8
    force_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.force_end && ctl.tend) |-> !mem_req);

    // R5
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.tend |-> !mem_req);
endmodule

// File: tb/pfifo_burst_dma_bench.sv
`timescale 1ns/1ps
module pfifo_burst_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_be;
    logic        mem_ack = 1'b0;
    logic        fifo_null = 1'b0;
    logic        irq;

    int nvec = 0;
    int nerr = 0;

    localparam logic [7:0] A_SRC = 8'h20, A_DST = 8'h24, A_CNT = 8'h28,
                           A_CTL = 8'h34, A_MSK = 8'h38, A_GLB = 8'h60, A_SWR = 8'h08;
    localparam logic [31:0] C_EN = 32'h1, C_TE = 32'h2, C_SP = 32'h4, C_DIR = 32'h8,
                            C_IE = 32'h20, C_TS32 = 32'h80, C_NUL = 32'h1000,
                            C_NULE = 32'h1_0000, C_FTE = 32'h100_0000;

    always #2.5 clk = ~clk;

    pfifo_burst_dma u_pfifo_burst_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_ack(mem_ack),
        .fifo_null(fifo_null), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 64 && !seen; i++) begin
            @(negedge clk);
            if (mem_req) seen = 1'b1;
        end
    endtask

    function automatic logic [31:0] mask_of(input int len);
        int n;
        n = len % 32;
        if (n == 0) n = 32;
        return 32'hFFFF_FFFF << (32 - n);
    endfunction

    task automatic run_xfer(input int len, input bit dir);
        logic [31:0] v, start, other, ctlw;
        int units;
        bit seen;
        bit ok;
        units = (len + 31) / 32;
        start = 32'h0001_0000 + 32'(len) * 32'h40;
        other = 32'h00F0_0000 + 32'(len);
        wr(dir ? A_DST : A_SRC, start);
        wr(dir ? A_SRC : A_DST, other);
        wr(A_CNT, 32'(units));
        wr(A_MSK, mask_of(len));
        ctlw = C_TS32 | C_NULE | C_IE | C_EN | (dir ? C_DIR : 32'h0);
        wr(A_CTL, ctlw);
        ok = 1'b1;
        for (int b = 0; b < units; b++) begin
            wait_req(seen);
            if (!seen) ok = 1'b0;
            // R3 address and direction, R4 byte mask
            chk("R3 burst addr", mem_addr, start + 32'(b) * 32);
            chk("R3 burst dir", {31'd0, mem_we}, {31'd0, dir});
            chk("R4 burst mask", mem_be, (b == units - 1) ? mask_of(len) : 32'hFFFF_FFFF);
            idle((len + b) % 3);
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
        end
        chk("R3 all bursts seen", {31'd0, ok}, 32'd1);
        for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
        // R5 end flag, irq, no more requests
        chk("R5 irq at end", {31'd0, irq}, 32'd1);
        chk("R5 no request after end", {31'd0, mem_req}, 32'd0);
        rd(A_CTL, v);
        chk("R5 end flag", v, ctlw | C_TE);
        rd(dir ? A_DST : A_SRC, v);
        chk("R5 final address", v, start + 32'(units) * 32);
        rd(dir ? A_SRC : A_DST, v);
        chk("R3 other address unchanged", v, other);
        rd(A_CNT, v);
        chk("R3 count zero", v, 32'd0);
        wr(A_CTL, 32'h0);
        #1;
        chk("R6 end cleared by write 0", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit seen;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(A_SRC, v); chk("R1 src", v, 0);
        rd(A_DST, v); chk("R1 dst", v, 0);
        rd(A_CNT, v); chk("R1 cnt", v, 0);
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        rd(A_MSK, v); chk("R1 mask", v, 0);
        rd(A_GLB, v); chk("R1 glb", v, 0);
        rd(A_SWR, v); chk("R1 swr", v, 0);
        chk("R1 irq/req", {30'd0, irq, mem_req}, 0);

        // R2 global enable
        wr(A_GLB, 32'h1);
        rd(A_GLB, v); chk("R2 enable readback", v, 32'h1);

        // R3 R4 R5 sweep
        for (int d = 0; d < 2; d++)
            for (int len = 1; len <= 96; len++)
                run_xfer(len, d[0]);

        // R6 field readback
        wr(A_MSK, 32'hA5C3_0F1E);
        rd(A_MSK, v); chk("R6 mask readback", v, 32'hA5C3_0F1E);
        wr(A_CTL, C_TS32 | C_IE | C_NULE | C_DIR | C_TE | C_SP | C_NUL);
        rd(A_CTL, v); chk("R6 write 1 to status ignored", v, C_TS32 | C_IE | C_NULE | C_DIR);
        wr(A_CTL, 0);

        // R7 null ignored when idle
        @(negedge clk); fifo_null = 1'b1; @(negedge clk); fifo_null = 1'b0;
        rd(A_CTL, v); chk("R7 idle null ignored", v, 0);

        // R2 pause with global enable 0
        wr(A_GLB, 32'h0);
        wr(A_SRC, 32'h0000_2000);
        wr(A_CNT, 32'd3);
        wr(A_CTL, C_EN | C_IE | C_NULE);
        idle(10);
        chk("R2 no request while disabled", {31'd0, mem_req}, 0);
        rd(A_CNT, v); chk("R2 count held", v, 3);
        // R7 null ignored with global enable 0
        @(negedge clk); fifo_null = 1'b1; @(negedge clk); fifo_null = 1'b0;
        rd(A_CTL, v); chk("R7 null ignored when disabled", v, C_EN | C_IE | C_NULE);
        wr(A_GLB, 32'h1);
        wait_req(seen);
        chk("R2 resumes", {31'd0, seen}, 1);
        chk("R2 resumed addr", mem_addr, 32'h0000_2000);

        // R7 null while busy, R9 null irq
        @(negedge clk); fifo_null = 1'b1; @(negedge clk); fifo_null = 1'b0;
        rd(A_CTL, v); chk("R7 null set", v, C_EN | C_IE | C_NULE | C_NUL);
        chk("R9 null irq", {31'd0, irq}, 1);
        // R8 null converted to forced end
        wr(A_CTL, C_EN | C_IE | C_NULE | C_FTE);
        idle(2);
        rd(A_CTL, v); chk("R8 forced end", v, C_EN | C_IE | C_NULE | C_FTE | C_TE);
        chk("R8 request stopped", {31'd0, mem_req}, 0);
        rd(A_CNT, v); chk("R8 count held", v, 3);
        chk("R9 end irq", {31'd0, irq}, 1);
        wr(A_CTL, 0);

        // R12 zero count, R9 irq masked
        wr(A_CNT, 32'd0);
        wr(A_CTL, C_EN);
        idle(2);
        rd(A_CTL, v); chk("R12 end without bursts", v, C_EN | C_TE);
        chk("R12 no request", {31'd0, mem_req}, 0);
        chk("R9 irq masked", {31'd0, irq}, 0);
        wr(A_CTL, 0);

        // R10 misaligned address
        wr(A_SRC, 32'h0000_3004);
        wr(A_CNT, 32'd2);
        wr(A_CTL, C_EN | C_IE);
        idle(2);
        chk("R10 no request", {31'd0, mem_req}, 0);
        rd(A_GLB, v); chk("R10 address error", v, 32'h3);
        rd(A_CTL, v); chk("R10 stop flag", v, C_EN | C_IE | C_SP);
        chk("R9 stop irq", {31'd0, irq}, 1);
        wr(A_GLB, 32'h3);
        rd(A_GLB, v); chk("R10 write 1 keeps error", v, 32'h3);
        wr(A_GLB, 32'h1);
        rd(A_GLB, v); chk("R10 error cleared", v, 32'h1);
        wr(A_CTL, 0);

        // R11 soft reset
        wr(A_SRC, 32'h0000_0055);
        wr(A_SWR, 32'h1);
        rd(A_SRC, v); chk("R11 src cleared", v, 0);
        rd(A_GLB, v); chk("R11 glb cleared", v, 0);
        wr(A_DST, 32'h0000_0077);
        rd(A_DST, v); chk("R11 write ignored", v, 0);
        rd(A_SWR, v); chk("R11 swr held", v, 1);
        wr(A_SWR, 32'h0);
        rd(A_SWR, v); chk("R11 swr released", v, 0);
        rd(A_DST, v); chk("R11 dst after release", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule